// File: doc/BRIEF.md
# Scan-Reuse Test Decompressor

This block is an embedded tester core that decompresses a serial test stream inside its own scan chains. It holds a set of equal-length internal chains joined end to end into one serial ring. A 2:1 feedback multiplexer sits at the ring head. It either takes a fresh bit from the narrow tester input or feeds the ring's own tail bit back in, which rotates the stored content. Because of this, a short stored stream can be overlapped and reused across many patterns.

The last cell of every internal chain drives, in parallel, the scan input of one chain of the core under test. Every shift therefore refreshes the stimulus on a wide, fast path. The core-under-test chain outputs enter a multi-input signature register, so responses are compacted without ever re-entering the stimulus ring. A serial unload mode moves the signature out one bit per clock.

Legality of the parameter set is checked at elaboration time:
- The core under test must have no more chains than the tester.
- Each of its chains must be no longer than a tester chain.
- Its total cell count must be coprime with the tester's total cell count plus one.

Top module: `scan_reuse_decomp`

## Requirements
- R1: While rst_n is low at a clock edge, every ring cell and every signature bit is cleared, so cut_si and misr_sig read all zeros afterwards.
- R2: On a clock with shift_en=1 and load_sel=1, tdi enters the first cell of chain 0. Every other cell takes the value of its predecessor, and the first cell of chain k (k>0) takes the last cell of chain k-1.
- R3: On a clock with shift_en=1 and load_sel=0, the ring head takes the last cell of the last chain. After exactly CHAINS*CHAIN_LEN such clocks, the ring holds the content it started with.
- R4: On a clock with shift_en=0, the ring content is unchanged. If misr_unload is also 0, the signature is unchanged as well.
- R5: cut_si[k] equals the last cell of tester chain k at all times, with no register between them. Chains are numbered in ring order from the head.
- R6: On a clock with shift_en=1 and misr_unload=0, the signature becomes (sig<<1) XOR (MISR_POLY if sig[MISR_W-1] was 1, else 0) XOR cut_so. Here cut_so is zero-extended, with cut_so[i] landing on bit i.
- R7: On a clock with misr_unload=1, the signature shifts left by one and takes 0 into bit 0, whatever shift_en and cut_so are. The ring still follows shift_en and load_sel.
- R8: misr_shift_out always equals the signature's most significant bit, so it presents the next bit to leave during unload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Advances the ring and enables response capture |
| load_sel | input | 1 | Feedback mux select: 1 takes tdi, 0 rotates |
| tdi | input | 1 | Serial bit from the narrow tester port |
| misr_unload | input | 1 | Puts the signature register into serial shift-out mode |
| cut_so | input | CHAINS | Scan outputs of the core-under-test chains |
| cut_si | output | CHAINS | Scan inputs driven to the core-under-test chains |
| misr_sig | output | MISR_W | Parallel signature value |
| misr_shift_out | output | 1 | Serial signature output (MSB) |

## Verification
The bench builds the block with four chains of eight cells and a 16-bit signature using polynomial 16'h002D. The core under test is configured as 4x8, so 32 and 33 are coprime. A 32-cell ring is short enough that a single directed rotation of 40 clocks passes the point where content wraps. This makes the exact return to the starting pattern after 32 rotations observable on cut_si. A signature four times wider than the input count lets unload tests push every bit, including bits created by polynomial feedback, through misr_shift_out.

// File: rtl/rsd_pkg.sv
// Package: shared helpers for the scan-reuse decompressor.
// Assumes: constant-function evaluation at elaboration time.
package rsd_pkg;

    // Greatest common divisor, used for the coprime legality rule.
    function automatic int unsigned rsd_gcd(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Full legality check of a tester/CUT pairing.
    function automatic bit rsd_cfg_legal(input int unsigned chains, input int unsigned len,
                                         input int unsigned cut_chains, input int unsigned cut_len);
        bit ok;
        ok = (cut_chains <= chains) && (cut_len <= len) && (cut_chains > 0) && (cut_len > 0);
        ok = ok && (rsd_gcd(cut_chains * cut_len, chains * len + 1) == 1);
        return ok;
    endfunction

endpackage

// File: rtl/rsd_scan_segment.sv
// Module: one reused tester scan chain of LEN cells.
// Cell 0 is the chain head, cell LEN-1 the tail that feeds both the next
// chain and one CUT scan input. Assumes LEN >= 1.
module rsd_scan_segment #(
    parameter int unsigned LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           seg_in,
    output logic [LEN-1:0] cells,
    output logic           seg_out
);

    generate
        if (LEN == 1) begin : g_single
            // Single cell: capture the head input when shifting.
            always_ff @(posedge clk) begin
                if (!rst_n)        cells <= '0;
                else if (shift_en) cells <= seg_in;
            end
        end else begin : g_multi
            // Multi-cell: move every bit one cell toward the tail.
            always_ff @(posedge clk) begin
                if (!rst_n)        cells <= '0;
                else if (shift_en) cells <= {cells[LEN-2:0], seg_in};
            end
        end
    endgenerate

    // Tail of the chain.
    assign seg_out = cells[LEN-1];

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cells)) else $error("segment moved without shift"); // R4

endmodule

// File: rtl/rsd_feedback_mux.sv
// Module: 2:1 feedback multiplexer at the ring head.
// Selects the tester bit when loading, otherwise the ring tail (rotation).
module rsd_feedback_mux (
    input  logic load_sel,
    input  logic tdi,
    input  logic ring_tail,
    output logic ring_head
);

    // Head source selection.
    always_comb begin
        ring_head = load_sel ? tdi : ring_tail;
    end

endmodule

// File: rtl/rsd_misr.sv
// Module: multi-input signature register with serial unload.
// Capture: Galois-style left shift with polynomial feedback plus parallel
// inputs on bits [IN_W-1:0]. Unload: plain left shift with zero fill,
// taking priority over capture. Assumes W >= IN_W and W >= 2.
module rsd_misr #(
    parameter int unsigned       W    = 16,
    parameter int unsigned       IN_W = 4,
    parameter logic [W-1:0]      POLY = 16'h002D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_en,
    input  logic            unload,
    input  logic [IN_W-1:0] resp_in,
    output logic [W-1:0]    sig,
    output logic            ser_out
);

    logic [W-1:0] resp_ext;
    logic [W-1:0] fb_term;
    logic [W-1:0] sig_next;

    // Zero-extend the response vector to the register width.
    always_comb begin
        resp_ext = '0;
        resp_ext[IN_W-1:0] = resp_in;
    end

    // Polynomial feedback driven by the outgoing MSB.
    always_comb begin
        fb_term = sig[W-1] ? POLY : '0;
    end

    // Next-state selection: unload beats capture, otherwise hold.
    always_comb begin
        if (unload)          sig_next = {sig[W-2:0], 1'b0};
        else if (capture_en) sig_next = {sig[W-2:0], 1'b0} ^ fb_term ^ resp_ext;
        else                 sig_next = sig;
    end

    // Signature state register.
    always_ff @(posedge clk) begin
        if (!rst_n) sig <= '0;
        else        sig <= sig_next;
    end

    // Serial output presents the MSB.
    assign ser_out = sig[W-1];

    AST_MISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !unload) |=> $stable(sig)) else $error("signature moved while idle"); // R4

    AST_MISR_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        unload |=> (sig[0] == 1'b0) && (sig[W-1:1] == $past(sig[W-2:0]))) else $error("unload shift wrong"); // R7

endmodule

// File: rtl/scan_reuse_decomp.sv
// Module: scan-reuse test decompressor top.
// CHAINS segments of CHAIN_LEN cells form one ring, head at chain 0.
// The feedback mux closes the ring from the tail of the last chain.
// Each chain tail drives one CUT scan input; CUT scan outputs feed the MISR.
// Assumes a legal pairing with a CUT of CUT_CHAINS x CUT_LEN cells.
module scan_reuse_decomp #(
    parameter int unsigned          CHAINS     = 4,
    parameter int unsigned          CHAIN_LEN  = 8,
    parameter int unsigned          CUT_CHAINS = 4,
    parameter int unsigned          CUT_LEN    = 8,
    parameter int unsigned          MISR_W     = 16,
    parameter logic [MISR_W-1:0]    MISR_POLY  = 16'h002D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              load_sel,
    input  logic              tdi,
    input  logic              misr_unload,
    input  logic [CHAINS-1:0] cut_so,
    output logic [CHAINS-1:0] cut_si,
    output logic [MISR_W-1:0] misr_sig,
    output logic              misr_shift_out
);
    import rsd_pkg::*;

    localparam int unsigned RING_CELLS = CHAINS * CHAIN_LEN;
    localparam int unsigned CUT_CELLS  = CUT_CHAINS * CUT_LEN;
    localparam bit          CFG_OK     = rsd_cfg_legal(CHAINS, CHAIN_LEN, CUT_CHAINS, CUT_LEN)
                                         && (MISR_W >= CHAINS) && (MISR_W >= 2);

    // Elaboration-time legality check of the parameter set.
    generate
        if (!CFG_OK) begin : g_cfg_bad
            $error("illegal pairing: CUT %0d cells vs ring %0d cells", CUT_CELLS, RING_CELLS);
        end
    endgenerate

    logic [CHAIN_LEN-1:0] seg_cells [CHAINS];
    logic [CHAINS-1:0]    seg_tail;
    logic [CHAINS-1:0]    seg_head;
    logic                 ring_head;

    // Feedback mux closing the ring.
    rsd_feedback_mux u_fbmux (
        .load_sel  (load_sel),
        .tdi       (tdi),
        .ring_tail (seg_tail[CHAINS-1]),
        .ring_head (ring_head)
    );

    // Chain instances; each head is fed by the previous tail.
    generate
        for (genvar k = 0; k < CHAINS; k++) begin : g_chain
            if (k == 0) begin : g_first
                assign seg_head[k] = ring_head;
            end else begin : g_link
                assign seg_head[k] = seg_tail[k-1];

                AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
                    shift_en |=> seg_cells[k][0] == $past(seg_cells[k-1][CHAIN_LEN-1]))
                    else $error("chain link broken"); // R2
            end

            rsd_scan_segment #(.LEN(CHAIN_LEN)) u_seg (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (shift_en),
                .seg_in   (seg_head[k]),
                .cells    (seg_cells[k]),
                .seg_out  (seg_tail[k])
            );

            // Parallel tap to the CUT chain.
            assign cut_si[k] = seg_tail[k];
        end
    endgenerate

    // Response compaction.
    rsd_misr #(.W(MISR_W), .IN_W(CHAINS), .POLY(MISR_POLY)) u_misr (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (shift_en),
        .unload     (misr_unload),
        .resp_in    (cut_so),
        .sig        (misr_sig),
        .ser_out    (misr_shift_out)
    );

    AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && load_sel) |=> seg_cells[0][0] == $past(tdi)) else $error("head missed tdi"); // R2

    AST_HEAD_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_sel) |=> seg_cells[0][0] == $past(seg_cells[CHAINS-1][CHAIN_LEN-1]))
        else $error("head missed tail"); // R3

endmodule

// File: tb/test_scan_reuse_decomp.sv
// Directed bench for scan_reuse_decomp with a bit-level reference model.
module test_scan_reuse_decomp;

    localparam int unsigned   N    = 4;
    localparam int unsigned   L    = 8;
    localparam int unsigned   RING = N * L;
    localparam int unsigned   W    = 16;
    localparam logic [W-1:0]  POLY = 16'h002D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         load_sel = 1'b0;
    logic         tdi = 1'b0;
    logic         misr_unload = 1'b0;
    logic [N-1:0] cut_so = '0;
    logic [N-1:0] cut_si;
    logic [W-1:0] misr_sig;
    logic         misr_shift_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [RING-1:0] ring_m = '0;
    logic [W-1:0]    misr_m = '0;

    always #5 clk = ~clk;

    scan_reuse_decomp #(
        .CHAINS(N), .CHAIN_LEN(L), .CUT_CHAINS(4), .CUT_LEN(8),
        .MISR_W(W), .MISR_POLY(POLY)
    ) i_scan_reuse_decomp (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load_sel(load_sel),
        .tdi(tdi), .misr_unload(misr_unload), .cut_so(cut_so),
        .cut_si(cut_si), .misr_sig(misr_sig), .misr_shift_out(misr_shift_out)
    );

    function automatic logic [N-1:0] taps(input logic [RING-1:0] r);
        logic [N-1:0] t;
        for (int k = 0; k < N; k++) t[k] = r[k*L + L - 1];
        return t;
    endfunction

    task automatic check_all(input string req);
        checks++;
        if (cut_si !== taps(ring_m)) begin
            errors++;
            $display("FAIL %s/R5 cut_si actual=%b expected=%b", req, cut_si, taps(ring_m));
        end
        checks++;
        if (misr_sig !== misr_m) begin
            errors++;
            $display("FAIL %s misr_sig actual=%h expected=%h", req, misr_sig, misr_m);
        end
        checks++;
        if (misr_shift_out !== misr_m[W-1]) begin
            errors++;
            $display("FAIL R8 misr_shift_out actual=%b expected=%b", misr_shift_out, misr_m[W-1]);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, check at next negedge.
    task automatic step(input logic se, input logic ls, input logic ti, input logic unl,
                        input logic [N-1:0] so, input string req);
        logic head;
        shift_en = se; load_sel = ls; tdi = ti; misr_unload = unl; cut_so = so;
        @(posedge clk);
        if (se) begin
            head = ls ? ti : ring_m[RING-1];
            ring_m = {ring_m[RING-2:0], head};
        end
        if (unl)     misr_m = {misr_m[W-2:0], 1'b0};
        else if (se) misr_m = {misr_m[W-2:0], 1'b0} ^ (misr_m[W-1] ? POLY : '0)
                              ^ {{(W-N){1'b0}}, so};
        @(negedge clk);
        check_all(req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; shift_en = 1'b0; misr_unload = 1'b0;
        @(posedge clk); @(posedge clk);
        ring_m = '0; misr_m = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
    endtask

    task automatic t_load();
        // A single 1 followed by zeros walks through every chain tail (R2, R5).
        step(1, 1, 1'b1, 0, '0, "R2");
        for (int i = 0; i < RING; i++) step(1, 1, 1'b0, 0, '0, "R2");
        for (int i = 0; i < RING; i++) step(1, 1, 1'($urandom), 0, '0, "R2");
    endtask

    task automatic t_rotate();
        logic [N-1:0] start_taps;
        logic [N-1:0] seq0 [RING];
        start_taps = cut_si;
        for (int i = 0; i < RING; i++) begin
            step(1, 0, 1'($urandom), 0, '0, "R3");
            seq0[i] = cut_si;
        end
        checks++;
        if (cut_si !== start_taps) begin
            errors++;
            $display("FAIL R3 after full revolution actual=%b expected=%b", cut_si, start_taps);
        end
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 1'b1, 0, '0, "R3");
            checks++;
            if (cut_si !== seq0[i]) begin
                errors++;
                $display("FAIL R3 second revolution actual=%b expected=%b", cut_si, seq0[i]);
            end
        end
    endtask

    task automatic t_hold();
        for (int i = 0; i < 6; i++) step(0, i[0], 1'($urandom), 0, N'($urandom), "R4");
    endtask

    task automatic t_capture();
        for (int i = 0; i < 40; i++) step(1, 1, 1'($urandom), 0, N'($urandom), "R6");
    endtask

    task automatic t_unload();
        // Unload with shift_en high and live cut_so: capture must be ignored (R7).
        for (int i = 0; i < W + 2; i++) step(i[0], 1, 1'($urandom), 1, N'($urandom), "R7");
        checks++;
        if (misr_sig !== '0) begin
            errors++;
            $display("FAIL R7 signature after full unload actual=%h expected=0", misr_sig);
        end
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 5; i++) step(1, 1, 1'b1, 0, {N{1'b1}}, "R6");
        t_reset();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_rotate();
        t_hold();
        t_capture();
        t_unload();
        t_capture();
        t_hold();
        t_reset_mid();
        t_load();
        t_rotate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule